// File: doc/BRIEF.md
# Flash Command State Machine

This block is the command front end of a NOR-style flash. Commands arrive as byte codes in the low eight bits of a word-wide write bus. The block steps through the one- and two-cycle sequences for word program, block erase, suspend and resume, and lock changes. It keeps a lock bit and a lock-down bit for each block and maintains an eight-bit status word. It also chooses what the read port returns: array contents, the status word, or identifier data.

Programming and erasing are modelled as busy periods of a fixed number of clock cycles. When a busy period ends, the block raises a one-cycle strobe toward the array: it carries the target address and data for a program, and the block index for an erase. The array itself lives outside the block. On an erase strobe the array must set every bit of the named block to one.

The address is split into two parts. The upper `BLK_W` bits select a block, and the remaining bits give the word offset inside that block.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset every block is locked and not locked-down, the read port returns `arr_rdata` (array source), and the status word reads 0x80.
- R2: Code 0xFF selects the array source, 0x70 selects the status source (status in `rd_data[7:0]`, upper bits zero), and 0x90 selects the identifier source. The setup codes 0x40, 0x10, 0x20 and 0x60 also switch the read port to status.
- R3: 0x40 or 0x10 followed by a data write starts a program. Status bit 7 reads 0 for exactly `BUSY_CYC` clock edges after the data write. On the next cycle a single `pgm_go` pulse carries the captured address and data.
- R4: 0x20 followed by 0xD0 starts an erase of the block addressed by the 0xD0 write. After `BUSY_CYC` edges a single `ers_go` pulse carries that block index.
- R5: A program or erase aimed at a locked block produces no strobe. It sets status bit 1 (lock error), plus bit 4 (program error) or bit 5 (erase error), and returns to ready.
- R6: 0x60 followed by 0x01 locks the addressed block, by 0xD0 unlocks it, and by 0x2F locks it down. In identifier mode, offset 0 of any block reads `ID_CODE`, and offset 2 reads the lock bit on bit 0 and the lock-down bit on bit 1.
- R7: A locked-down block stays locked and locked-down through unlock commands until reset.
- R8: 0xB0 during a busy period suspends it. Status bit 7 then reads 1, and bit 2 (program) or bit 6 (erase) is set. The remaining cycle count is frozen. 0xD0 resumes the operation, and it finishes with its strobe.
- R9: During a program suspend, 0x60 and any following lock code leave all lock state unchanged.
- R10: During an erase suspend, a lock sequence changes the block's lock state at once. The suspended erase still completes with its strobe after resume.
- R11: Code 0x50 clears status bits 5, 4 and 1.
- R12: A second cycle other than 0xD0 after 0x20, or other than 0x01/0xD0/0x2F after 0x60, sets status bits 5 and 4, changes no lock state, issues no strobe, and returns to the prior idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command/data write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address; top BLK_W bits select the block |
| wr_data | input | DATA_W | Write data; command code in bits 7:0 |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | DATA_W | Array word at rd_addr from the external array |
| rd_data | output | DATA_W | Selected read data (array, status or identifier) |
| pgm_go | output | 1 | One-cycle program commit strobe |
| pgm_addr | output | ADDR_W | Program target address |
| pgm_data | output | DATA_W | Program data |
| ers_go | output | 1 | One-cycle erase commit strobe |
| ers_blk | output | BLK_W | Erase target block |

## Verification
The bench builds the block with `ADDR_W` = 8, `BLK_W` = 2 and `BUSY_CYC` = 4. This gives four blocks of 64 words each, so it is cheap to visit every block's lock state, including one locked-down block beside three ordinary ones. A four-cycle busy period is short enough to count edge by edge, so the exact cycle of the commit strobe is checked. It is also long enough that a suspend written two cycles after the start lands inside the busy window, which lets the bench exercise the frozen count and the resume.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;

    typedef enum logic [3:0] {
        ST_READY,
        ST_PGM_SETUP,
        ST_ERS_SETUP,
        ST_LCK_SETUP,
        ST_LCK_SETUP_ES,
        ST_PGM_BUSY,
        ST_ERS_BUSY,
        ST_PGM_SUSP,
        ST_ERS_SUSP
    } fsm_state_e;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_STATUS,
        RD_IDENT
    } rd_src_e;

    typedef enum logic [1:0] {
        LK_NONE,
        LK_LOCK,
        LK_UNLOCK,
        LK_DOWN
    } lock_op_e;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_READ_IDENT = 8'h90;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_PGM_A      = 8'h40;
    localparam logic [7:0] CMD_PGM_B      = 8'h10;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
    localparam logic [7:0] CMD_LCK_SETUP  = 8'h60;
    localparam logic [7:0] CMD_LCK_SET    = 8'h01;
    localparam logic [7:0] CMD_LCK_DOWN   = 8'h2F;

    // status word bit positions
    localparam int SB_READY  = 7;
    localparam int SB_ESUSP  = 6;
    localparam int SB_EERR   = 5;
    localparam int SB_PERR   = 4;
    localparam int SB_PSUSP  = 2;
    localparam int SB_LERR   = 1;

endpackage

// File: rtl/fcsm_lock_table.sv
module fcsm_lock_table
    import fcsm_pkg::*;
#(
    parameter int BLK_W = 2,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lock_op_e         op,
    input  logic [BLK_W-1:0] blk,
    output logic [NBLK-1:0]  locked,
    output logic [NBLK-1:0]  ldown
);

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic lk_d, lk_q, ld_d, ld_q;
        logic hit;

        assign hit = (blk == BLK_W'(g));

        always_comb begin
            lk_d = lk_q;
            ld_d = ld_q;
            if (hit) begin
                case (op)
                    LK_LOCK:   lk_d = 1'b1;
                    LK_UNLOCK: lk_d = ld_q;
                    LK_DOWN: begin
                        lk_d = 1'b1;
                        ld_d = 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lk_q <= 1'b1;
                ld_q <= 1'b0;
            end else begin
                lk_q <= lk_d;
                ld_q <= ld_d;
            end
        end

        assign locked[g] = lk_q;
        assign ldown[g]  = ld_q;

        AST_LDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ld_q |=> ld_q); // R7
        AST_LDOWN_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            ld_q |=> lk_q); // R7
    end

endmodule

// File: rtl/fcsm_busy_timer.sv
module fcsm_busy_timer #(
    parameter int BUSY_CYC = 4,
    localparam int CNT_W = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(BUSY_CYC - 1);
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == '0);

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/fcsm_read_mux.sv
module fcsm_read_mux
    import fcsm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 2,
    parameter logic [DATA_W-1:0] ID_CODE = 16'h0018,
    localparam int NBLK  = 1 << BLK_W,
    localparam int OFF_W = ADDR_W - BLK_W
) (
    input  rd_src_e           src,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [7:0]        status,
    input  logic [NBLK-1:0]   locked,
    input  logic [NBLK-1:0]   ldown,
    output logic [DATA_W-1:0] rd_data
);

    logic [BLK_W-1:0] rblk;
    logic [OFF_W-1:0] roff;

    assign rblk = rd_addr[ADDR_W-1 -: BLK_W];
    assign roff = rd_addr[OFF_W-1:0];

    always_comb begin
        rd_data = '0;
        case (src)
            RD_ARRAY:  rd_data = arr_rdata;
            RD_STATUS: rd_data = {{(DATA_W-8){1'b0}}, status};
            RD_IDENT: begin
                if (roff == OFF_W'(0))      rd_data = ID_CODE;
                else if (roff == OFF_W'(2)) rd_data = {{(DATA_W-2){1'b0}}, ldown[rblk], locked[rblk]};
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import fcsm_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int BLK_W    = 2,
    parameter int BUSY_CYC = 4,
    parameter logic [DATA_W-1:0] ID_CODE = 16'h0018,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              pgm_go,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              ers_go,
    output logic [BLK_W-1:0]  ers_blk
);

    typedef struct packed {
        fsm_state_e        st;
        rd_src_e           rsrc;
        logic              pgm_err;
        logic              ers_err;
        logic              lck_err;
        logic              pgm_go;
        logic              ers_go;
        logic [ADDR_W-1:0] taddr;
        logic [DATA_W-1:0] tdata;
    } regs_t;

    localparam regs_t RST_V = '{ST_READY, RD_ARRAY, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

    regs_t d, q;

    logic [7:0]       cmd;
    logic [BLK_W-1:0] wblk;
    logic [NBLK-1:0]  locked, ldown;
    lock_op_e         lk_op;
    logic             tmr_start, tmr_run, tmr_done;
    logic [7:0]       status;

    assign cmd  = wr_data[7:0];
    assign wblk = wr_addr[ADDR_W-1 -: BLK_W];

    assign tmr_run = (q.st == ST_PGM_BUSY) || (q.st == ST_ERS_BUSY);

    always_comb begin
        d         = q;
        d.pgm_go  = 1'b0;
        d.ers_go  = 1'b0;
        lk_op     = LK_NONE;
        tmr_start = 1'b0;

        case (q.st)
            ST_READY: if (wr_en) begin
                case (cmd)
                    CMD_READ_ARRAY: d.rsrc = RD_ARRAY;
                    CMD_READ_STAT:  d.rsrc = RD_STATUS;
                    CMD_READ_IDENT: d.rsrc = RD_IDENT;
                    CMD_CLR_STAT: begin
                        d.pgm_err = 1'b0;
                        d.ers_err = 1'b0;
                        d.lck_err = 1'b0;
                    end
                    CMD_PGM_A, CMD_PGM_B: begin
                        d.st   = ST_PGM_SETUP;
                        d.rsrc = RD_STATUS;
                    end
                    CMD_ERASE: begin
                        d.st   = ST_ERS_SETUP;
                        d.rsrc = RD_STATUS;
                    end
                    CMD_LCK_SETUP: begin
                        d.st   = ST_LCK_SETUP;
                        d.rsrc = RD_STATUS;
                    end
                    default: ;
                endcase
            end

            ST_PGM_SETUP: if (wr_en) begin
                if (locked[wblk]) begin
                    d.pgm_err = 1'b1;
                    d.lck_err = 1'b1;
                    d.st      = ST_READY;
                end else begin
                    d.taddr   = wr_addr;
                    d.tdata   = wr_data;
                    d.st      = ST_PGM_BUSY;
                    tmr_start = 1'b1;
                end
            end

            ST_ERS_SETUP: if (wr_en) begin
                if (cmd != CMD_CONFIRM) begin
                    d.pgm_err = 1'b1;
                    d.ers_err = 1'b1;
                    d.st      = ST_READY;
                end else if (locked[wblk]) begin
                    d.ers_err = 1'b1;
                    d.lck_err = 1'b1;
                    d.st      = ST_READY;
                end else begin
                    d.taddr   = wr_addr;
                    d.st      = ST_ERS_BUSY;
                    tmr_start = 1'b1;
                end
            end

            ST_LCK_SETUP, ST_LCK_SETUP_ES: if (wr_en) begin
                d.st = (q.st == ST_LCK_SETUP_ES) ? ST_ERS_SUSP : ST_READY;
                case (cmd)
                    CMD_LCK_SET:  lk_op = LK_LOCK;
                    CMD_CONFIRM:  lk_op = LK_UNLOCK;
                    CMD_LCK_DOWN: lk_op = LK_DOWN;
                    default: begin
                        d.pgm_err = 1'b1;
                        d.ers_err = 1'b1;
                    end
                endcase
            end

            ST_PGM_BUSY, ST_ERS_BUSY: begin
                if (tmr_done) begin
                    d.st     = ST_READY;
                    d.pgm_go = (q.st == ST_PGM_BUSY);
                    d.ers_go = (q.st == ST_ERS_BUSY);
                end else if (wr_en) begin
                    if (cmd == CMD_SUSPEND) begin
                        d.st   = (q.st == ST_PGM_BUSY) ? ST_PGM_SUSP : ST_ERS_SUSP;
                        d.rsrc = RD_STATUS;
                    end else if (cmd == CMD_READ_STAT) begin
                        d.rsrc = RD_STATUS;
                    end
                end
            end

            ST_PGM_SUSP, ST_ERS_SUSP: if (wr_en) begin
                case (cmd)
                    CMD_READ_ARRAY: d.rsrc = RD_ARRAY;
                    CMD_READ_STAT:  d.rsrc = RD_STATUS;
                    CMD_READ_IDENT: d.rsrc = RD_IDENT;
                    CMD_CLR_STAT: begin
                        d.pgm_err = 1'b0;
                        d.ers_err = 1'b0;
                        d.lck_err = 1'b0;
                    end
                    CMD_CONFIRM: begin
                        d.st   = (q.st == ST_PGM_SUSP) ? ST_PGM_BUSY : ST_ERS_BUSY;
                        d.rsrc = RD_STATUS;
                    end
                    CMD_LCK_SETUP: begin
                        if (q.st == ST_ERS_SUSP) begin
                            d.st   = ST_LCK_SETUP_ES;
                            d.rsrc = RD_STATUS;
                        end
                    end
                    default: ;
                endcase
            end

            default: d.st = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_V;
        else        q <= d;
    end

    always_comb begin
        status           = '0;
        status[SB_READY] = !tmr_run;
        status[SB_ESUSP] = (q.st == ST_ERS_SUSP) || (q.st == ST_LCK_SETUP_ES);
        status[SB_EERR]  = q.ers_err;
        status[SB_PERR]  = q.pgm_err;
        status[SB_PSUSP] = (q.st == ST_PGM_SUSP);
        status[SB_LERR]  = q.lck_err;
    end

    fcsm_lock_table #(.BLK_W(BLK_W)) i_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (lk_op),
        .blk    (wblk),
        .locked (locked),
        .ldown  (ldown)
    );

    fcsm_busy_timer #(.BUSY_CYC(BUSY_CYC)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .run   (tmr_run),
        .done  (tmr_done)
    );

    fcsm_read_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BLK_W  (BLK_W),
        .ID_CODE(ID_CODE)
    ) i_rmux (
        .src       (q.rsrc),
        .rd_addr   (rd_addr),
        .arr_rdata (arr_rdata),
        .status    (status),
        .locked    (locked),
        .ldown     (ldown),
        .rd_data   (rd_data)
    );

    assign pgm_go   = q.pgm_go;
    assign pgm_addr = q.taddr;
    assign pgm_data = q.tdata;
    assign ers_go   = q.ers_go;
    assign ers_blk  = q.taddr[ADDR_W-1 -: BLK_W];

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_go, ers_go})); // R3
    AST_PGM_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgm_go) |-> $past(q.st == ST_PGM_BUSY)); // R3
    AST_ERS_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ers_go) |-> $past(q.st == ST_ERS_BUSY)); // R4
    AST_PGM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_go |-> !locked[pgm_addr[ADDR_W-1 -: BLK_W]]); // R5
    AST_LERR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.lck_err) |-> $past(wr_en)); // R5
    AST_PSUSP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PGM_SUSP) |=> (q.st == ST_PGM_SUSP || q.st == ST_PGM_BUSY)); // R8
    AST_PSUSP_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PGM_SUSP) |=> ($stable(locked) && $stable(ldown))); // R9

endmodule

// File: tb/test_flash_cmd_fsm.sv
module test_flash_cmd_fsm;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int BLK_W    = 2;
    localparam int BUSY_CYC = 4;
    localparam logic [15:0] IDC = 16'h0018;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [15:0] ARR_PAT = 16'hA5A5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] arr_rdata = ARR_PAT;
    logic [DATA_W-1:0] rd_data;
    logic              pgm_go, ers_go;
    logic [ADDR_W-1:0] pgm_addr;
    logic [DATA_W-1:0] pgm_data;
    logic [BLK_W-1:0]  ers_blk;

    int checks = 0;
    int errors = 0;
    int pgm_cnt = 0;
    int ers_cnt = 0;
    logic [ADDR_W-1:0] last_paddr = '0;
    logic [DATA_W-1:0] last_pdata = '0;
    logic [BLK_W-1:0]  last_eblk = '0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
        .BUSY_CYC(BUSY_CYC), .ID_CODE(IDC)
    ) i_flash_cmd_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .pgm_go(pgm_go), .pgm_addr(pgm_addr),
        .pgm_data(pgm_data), .ers_go(ers_go), .ers_blk(ers_blk)
    );

    always @(negedge clk) begin
        if (pgm_go) begin
            pgm_cnt++;
            last_paddr = pgm_addr;
            last_pdata = pgm_data;
        end
        if (ers_go) begin
            ers_cnt++;
            last_eblk = ers_blk;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic [ADDR_W-1:0] base(int b);
        return ADDR_W'(b << (ADDR_W - BLK_W));
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic lock_cmd(int b, logic [7:0] c);
        wr(base(b), 16'h0060);
        wr(base(b), {8'h00, c});
    endtask

    task automatic lock_bits(int b, output logic [DATA_W-1:0] v);
        wr(base(b), 16'h0090);
        rd(base(b) | ADDR_W'(2), v);
    endtask

    task automatic stat(output logic [DATA_W-1:0] v);
        wr('0, 16'h0070);
        rd('0, v);
    endtask

    task automatic wait_ready();
        logic [DATA_W-1:0] v;
        for (int i = 0; i < 64; i++) begin
            rd('0, v);
            if (v[7]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] v;
        do_reset();
        rd(8'h13, v);
        check("R1 array source after reset", v, ARR_PAT);
        stat(v);
        check("R1 status after reset", v, 16'h0080);
        for (int b = 0; b < 4; b++) begin
            lock_bits(b, v);
            check("R1 block locked after reset", v, 16'h0001);
        end
        rd(base(2), v);
        check("R6 identifier code at offset 0", v, IDC);
    endtask

    task automatic t_read_modes();
        logic [DATA_W-1:0] v;
        wr('0, 16'h00FF);
        rd(8'h21, v);
        check("R2 0xFF selects array", v, ARR_PAT);
        wr('0, 16'h0070);
        rd(8'h21, v);
        check("R2 0x70 selects status", v, 16'h0080);
        wr('0, 16'h0090);
        rd(8'h00, v);
        check("R2 0x90 selects identifier", v, IDC);
        wr('0, 16'h00FF);
        wr(base(1), 16'h0060);
        rd('0, v);
        check("R2 setup switches to status", v, 16'h0080);
        wr(base(1), 16'h0001);
    endtask

    task automatic t_locked_ops();
        logic [DATA_W-1:0] v;
        int p0 = pgm_cnt, e0 = ers_cnt;
        wr(base(1) | 8'h05, 16'h0040);
        wr(base(1) | 8'h05, 16'h7777);
        repeat (BUSY_CYC + 2) @(negedge clk);
        rd('0, v);
        check("R5 program on locked block status", v, 16'h0092);
        check("R5 no program strobe", 32'(pgm_cnt - p0), 0);
        wr('0, 16'h0050);
        rd('0, v);
        check("R11 clear status", v, 16'h0080);
        wr(base(0), 16'h0020);
        wr(base(0), 16'h00D0);
        repeat (BUSY_CYC + 2) @(negedge clk);
        rd('0, v);
        check("R5 erase on locked block status", v, 16'h00A2);
        check("R5 no erase strobe", 32'(ers_cnt - e0), 0);
        wr('0, 16'h0050);
    endtask

    task automatic t_program();
        logic [DATA_W-1:0] v;
        int p0;
        lock_cmd(1, 8'hD0);
        lock_bits(1, v);
        check("R6 unlock clears lock bit", v, 16'h0000);
        p0 = pgm_cnt;
        wr(base(1), 16'h0010);
        wr(8'h45, 16'h1234);
        for (int i = 0; i < BUSY_CYC - 1; i++) begin
            rd('0, v);
            check("R3 busy during program", 32'(v[7]), 0);
            @(negedge clk);
        end
        rd('0, v);
        check("R3 still busy on last count", 32'(v[7]), 0);
        check("R3 no early strobe", 32'(pgm_cnt - p0), 0);
        @(negedge clk);
        rd('0, v);
        check("R3 ready after busy period", v, 16'h0080);
        check("R3 one program strobe", 32'(pgm_cnt - p0), 1);
        check("R3 program address", 32'(last_paddr), 32'h45);
        check("R3 program data", 32'(last_pdata), 32'h1234);
    endtask

    task automatic t_erase();
        logic [DATA_W-1:0] v;
        int e0 = ers_cnt;
        lock_cmd(2, 8'hD0);
        wr(base(2) | 8'h03, 16'h0020);
        wr(base(2) | 8'h03, 16'h00D0);
        repeat (BUSY_CYC) @(negedge clk);
        rd('0, v);
        check("R4 erase done status", v, 16'h0080);
        check("R4 one erase strobe", 32'(ers_cnt - e0), 1);
        check("R4 erase block index", 32'(last_eblk), 2);
    endtask

    task automatic t_unknown();
        logic [DATA_W-1:0] v;
        int e0 = ers_cnt;
        wr(base(2), 16'h0020);
        wr(base(2), 16'h0033);
        repeat (BUSY_CYC + 2) @(negedge clk);
        rd('0, v);
        check("R12 bad erase confirm status", v, 16'h00B0);
        check("R12 no erase strobe", 32'(ers_cnt - e0), 0);
        wr('0, 16'h0050);
        lock_cmd(2, 8'h77);
        rd('0, v);
        check("R12 bad lock code status", v, 16'h00B0);
        lock_bits(2, v);
        check("R12 lock state unchanged", v, 16'h0000);
        wr('0, 16'h0050);
    endtask

    task automatic t_lockdown();
        logic [DATA_W-1:0] v;
        lock_cmd(3, 8'h2F);
        lock_bits(3, v);
        check("R6 lock-down bits", v, 16'h0003);
        lock_cmd(3, 8'hD0);
        lock_bits(3, v);
        check("R7 unlock refused after lock-down", v, 16'h0003);
        lock_cmd(0, 8'h01);
        lock_bits(0, v);
        check("R6 lock command", v, 16'h0001);
    endtask

    task automatic t_pgm_suspend();
        logic [DATA_W-1:0] v;
        int p0 = pgm_cnt;
        wr(base(1) | 8'h08, 16'h0040);
        wr(base(1) | 8'h08, 16'hBEEF);
        wr('0, 16'h00B0);
        rd('0, v);
        check("R8 program suspend status", v, 16'h0084);
        repeat (3 * BUSY_CYC) @(negedge clk);
        check("R8 no strobe while suspended", 32'(pgm_cnt - p0), 0);
        lock_cmd(2, 8'h01);
        wr('0, 16'h0090);
        rd(base(2) | 8'h02, v);
        check("R9 lock refused in program suspend", v, 16'h0000);
        wr('0, 16'h00D0);
        wait_ready();
        @(negedge clk);
        check("R8 resumed program completes", 32'(pgm_cnt - p0), 1);
        check("R8 resumed program data", 32'(last_pdata), 32'hBEEF);
    endtask

    task automatic t_ers_suspend();
        logic [DATA_W-1:0] v;
        int e0 = ers_cnt;
        wr(base(2), 16'h0020);
        wr(base(2), 16'h00D0);
        wr('0, 16'h00B0);
        rd('0, v);
        check("R8 erase suspend status", v, 16'h00C0);
        lock_cmd(2, 8'h01);
        wr('0, 16'h0090);
        rd(base(2) | 8'h02, v);
        check("R10 lock immediate in erase suspend", v, 16'h0001);
        check("R10 no strobe before resume", 32'(ers_cnt - e0), 0);
        wr('0, 16'h00D0);
        wait_ready();
        @(negedge clk);
        check("R10 suspended erase completes", 32'(ers_cnt - e0), 1);
        check("R10 erase block index", 32'(last_eblk), 2);
    endtask

    task automatic t_reset_clears_down();
        logic [DATA_W-1:0] v;
        do_reset();
        lock_bits(3, v);
        check("R7 reset clears lock-down", v, 16'h0001);
    endtask

    initial begin
        t_reset();
        t_read_modes();
        t_locked_ops();
        t_program();
        t_erase();
        t_unknown();
        t_lockdown();
        t_pgm_suspend();
        t_ers_suspend();
        t_reset_clears_down();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule